// File: doc/BRIEF.md
# Link Port Output Sequencer

This block turns receiver output samples into a byte stream for a point-to-point link port. It draws 32-bit IQ words from four filter channels, or IQ words and 12-bit signal-strength (RSSI) words from two AGC units named A and B. It packs them into 16-byte quad-words and sends one byte per clock. A single 8-bit control register sets the following:
- whether the port is on;
- which source family feeds it;
- the order in which channels or units take turns;
- whether RSSI words are carried;
- how long to wait after the receiver raises data-ready.

Each source hands over words through its own valid/ready pair. The sequencer pulls exactly one word per handshake. It holds its output idle when the word it needs next is not yet offered. The mode for a quad-word is captured when that quad-word's start is accepted, so a register write during a transfer takes effect on the next quad-word.

Top module: `linkport_seq`

## Requirements
- R1: After synchronous reset the control register reads as all zeros (port off), `lp_valid` is low and every ready output is low.
- R2: While control bit 7 (enable) is 0, no byte is sent, no ready is raised, and a data-ready seen in that time starts nothing later.
- R3: With bit 0 = 0 (filter source) and bit 1 = 0, a quad-word carries IQ words of channels 0, 1, 0, 1. Each word is sent as four bytes, bits 31:24 first, so the I half (bits 31:16) goes before the Q half.
- R4: With bit 0 = 0 and bit 1 = 1, a quad-word carries IQ words of channels 0, 1, 2, 3 in that order.
- R5: With filter source selected, bit 2 has no effect on the bytes sent.
- R6: With bit 0 = 1 (AGC source), bit 1 = 0 and bit 2 = 1 (RSSI off), a quad-word carries IQ words of A, B, A, B.
- R7: With bit 0 = 1, bit 1 = 0 and bit 2 = 0, a quad-word is the following 16 bytes: A IQ (4), A RSSI (2), B IQ (4), B RSSI (2), then four zero bytes. An RSSI word is the 12-bit value followed by four zero bits, upper byte first.
- R8: With bit 0 = 1 and bit 1 = 1, a quad-word is B IQ (4), B RSSI (2), then ten zero bytes, whatever the value of bit 2.
- R9: Bits 6:3 hold delay D. Take N = max(D, 6). The first byte of a quad-word is on the output after the (N+1)-th rising edge that follows the edge that sampled data-ready, provided the needed source is valid.
- R10: When the source of the next needed word is not valid, `lp_valid` stays low, and the stream resumes with no byte lost or repeated once it becomes valid.
- R11: The mode bits are captured when a quad-word starts. A write during a transfer changes only later quad-words. Exactly 16 bytes are sent back to back per quad-word, after which `lp_valid` falls.
- R12: At most one ready output is high in any cycle, a ready is only high while its valid is high, and each word of a quad-word is taken by exactly one handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| rx_rdy | input | 1 | Data-ready from the downstream receiver |
| flt_valid | input | FLT_CH | Filter channel word offered |
| flt_data | input | FLT_CH*32 | Filter channel IQ words, channel c in bits 32c+31:32c |
| flt_ready | output | FLT_CH | Filter channel word taken |
| agc_iq_valid | input | AGC_CH | AGC IQ word offered (index 0 = A, 1 = B) |
| agc_iq_data | input | AGC_CH*32 | AGC IQ words |
| agc_iq_ready | output | AGC_CH | AGC IQ word taken |
| agc_rssi_valid | input | AGC_CH | AGC RSSI word offered |
| agc_rssi_data | input | AGC_CH*RSSI_W | AGC RSSI values |
| agc_rssi_ready | output | AGC_CH | AGC RSSI word taken |
| lp_valid | output | 1 | Byte present on `lp_data` |
| lp_data | output | 8 | Link port byte |

## Verification
The first byte is due N+2 falling edges after the falling edge at which the bench raises data-ready. That is one edge to sample data-ready, N edges of waiting, and one edge to register the byte. The bench counts falling edges and compares that count against a latency stored in its vector table. The remaining 15 bytes follow on consecutive falling edges unless a source is withheld, and `lp_valid` must be low one edge after the last byte. Ready outputs are combinational, so they are sampled at the falling edge of the same cycle and summed over the whole quad-word.

// File: rtl/lpseq_pkg.sv
// Shared types for the link port output sequencer.
// Assumes 32-bit IQ words and at most four slots per quad-word.
package lpseq_pkg;

    localparam int IQ_BITS    = 32;
    localparam int QUAD_BYTES = 16;
    localparam int SLOTS      = 4;

    typedef enum logic [1:0] {
        ITEM_PAD  = 2'd0,
        ITEM_IQ   = 2'd1,
        ITEM_RSSI = 2'd2
    } item_kind_e;

    typedef struct packed {
        item_kind_e kind;
        logic [1:0] sel;
    } item_t;

    // Field order follows the control byte, bit 7 first.
    typedef struct packed {
        logic       en;
        logic [3:0] dly;
        logic       no_rssi;
        logic       pat;
        logic       use_agc;
    } ctrl_t;

    // Returns the word that fills a given slot of a quad-word under a mode.
    function automatic item_t slot_item(input ctrl_t c, input logic [2:0] slot);
        item_t it;
        it.kind = ITEM_PAD;
        it.sel  = 2'd0;
        if (slot < 3'(SLOTS)) begin
            if (!c.use_agc) begin
                it.kind = ITEM_IQ;
                it.sel  = c.pat ? slot[1:0] : {1'b0, slot[0]};
            end else if (c.pat) begin
                // Unit B only, RSSI always carried.
                if (slot == 3'd0) begin
                    it.kind = ITEM_IQ;
                    it.sel  = 2'd1;
                end else if (slot == 3'd1) begin
                    it.kind = ITEM_RSSI;
                    it.sel  = 2'd1;
                end
            end else if (c.no_rssi) begin
                it.kind = ITEM_IQ;
                it.sel  = {1'b0, slot[0]};
            end else begin
                it.kind = slot[0] ? ITEM_RSSI : ITEM_IQ;
                it.sel  = {1'b0, slot[1]};
            end
        end
        return it;
    endfunction

endpackage

// File: rtl/lpseq_ctrl_reg.sv
// Control register of the sequencer.
// Assumes a single write strobe carrying the full byte.
module lpseq_ctrl_reg
    import lpseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output ctrl_t      ctrl
);

    // Capture a written byte; reset leaves the port off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (we) begin
            ctrl <= ctrl_t'(wdata);
        end
    end

endmodule

// File: rtl/lpseq_start_timer.sv
// Start-delay timer. It accepts data-ready only while the port is on and no
// quad-word is in flight. It then waits max(dly, MIN_WAIT) cycles and
// raises go for one cycle.
// Assumes the packer raises busy on the edge at which go is high.
module lpseq_start_timer #(
    parameter int DLY_W    = 4,
    parameter int MIN_WAIT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rx_rdy,
    input  logic             busy,
    input  logic [DLY_W-1:0] dly,
    output logic             go
);

    localparam int MW_W  = $clog2(MIN_WAIT + 1);
    localparam int CNT_W = (DLY_W > MW_W) ? DLY_W : MW_W;
    localparam int WC_W  = CNT_W + 1;

    logic             waiting;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;
    logic [WC_W-1:0]  wc;

    // Wait length minus one, never below the minimum.
    always_comb begin
        if (CNT_W'(dly) < CNT_W'(MIN_WAIT)) begin
            load_val = CNT_W'(MIN_WAIT - 1);
        end else begin
            load_val = CNT_W'(dly) - CNT_W'(1);
        end
    end

    assign go = waiting && (cnt == '0);

    // Count down from the accepted data-ready to go.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            waiting <= 1'b0;
            cnt     <= '0;
        end else if (!waiting) begin
            if (rx_rdy && !busy) begin
                waiting <= 1'b1;
                cnt     <= load_val;
            end
        end else if (cnt == '0) begin
            waiting <= 1'b0;
        end else begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // Independent tally of cycles spent waiting, used by the checker below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wc <= '0;
        end else if (!waiting) begin
            wc <= WC_W'(1);
        end else if (wc != '1) begin
            wc <= wc + WC_W'(1);
        end
    end

    p_min_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (wc >= WC_W'(MIN_WAIT)));

endmodule

// File: rtl/lpseq_byte_packer.sv
// Byte engine. On go it captures the mode and walks the slots of one
// quad-word. It pulls each word through its source's handshake, shifts it
// out most significant byte first, and pads with zero bytes up to 16.
// Assumes go never arrives while busy.
module lpseq_byte_packer
    import lpseq_pkg::*;
#(
    parameter int FLT_CH = 4,
    parameter int AGC_CH = 2,
    parameter int RSSI_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     go,
    input  ctrl_t                    ctrl,
    input  logic [FLT_CH-1:0]        flt_valid,
    input  logic [FLT_CH*32-1:0]     flt_data,
    output logic [FLT_CH-1:0]        flt_ready,
    input  logic [AGC_CH-1:0]        agc_iq_valid,
    input  logic [AGC_CH*32-1:0]     agc_iq_data,
    output logic [AGC_CH-1:0]        agc_iq_ready,
    input  logic [AGC_CH-1:0]        agc_rssi_valid,
    input  logic [AGC_CH*RSSI_W-1:0] agc_rssi_data,
    output logic [AGC_CH-1:0]        agc_rssi_ready,
    output logic                     busy,
    output logic                     lp_valid,
    output logic [7:0]               lp_data
);

    localparam int RSSI_PAD = 16 - RSSI_W;
    localparam int BC_W     = $clog2(QUAD_BYTES);

    ctrl_t                    mode;
    logic [BC_W-1:0]          byte_cnt;
    logic [2:0]               slot;
    logic [1:0]               rem;
    logic [IQ_BITS-9:0]       hold;
    item_t                    item;
    logic                     src_valid;
    logic [IQ_BITS-1:0]       src_word;
    logic                     need_fetch;
    logic                     take;
    logic                     emit;

    assign item = slot_item(mode, slot);

    // Select the valid flag and word of the source the current slot names.
    always_comb begin
        src_valid = 1'b0;
        src_word  = '0;
        if (item.kind == ITEM_IQ && !mode.use_agc) begin
            for (int c = 0; c < FLT_CH; c++) begin
                if (int'(item.sel) == c) begin
                    src_valid = flt_valid[c];
                    src_word  = flt_data[c*32 +: 32];
                end
            end
        end else if (item.kind == ITEM_IQ) begin
            for (int a = 0; a < AGC_CH; a++) begin
                if (int'(item.sel) == a) begin
                    src_valid = agc_iq_valid[a];
                    src_word  = agc_iq_data[a*32 +: 32];
                end
            end
        end else if (item.kind == ITEM_RSSI) begin
            for (int a = 0; a < AGC_CH; a++) begin
                if (int'(item.sel) == a) begin
                    src_valid = agc_rssi_valid[a];
                    src_word  = {agc_rssi_data[a*RSSI_W +: RSSI_W], {RSSI_PAD{1'b0}}, 16'h0000};
                end
            end
        end
    end

    assign need_fetch = busy && en && (rem == 2'd0) && (item.kind != ITEM_PAD);
    assign take       = need_fetch && src_valid;
    assign emit       = busy && en && ((rem != 2'd0) || (item.kind == ITEM_PAD) || take);

    // One ready line per source, raised only in the cycle its word is taken.
    generate
        for (genvar c = 0; c < FLT_CH; c++) begin : g_flt_rdy
            assign flt_ready[c] = take && !mode.use_agc && (int'(item.sel) == c);
        end
        for (genvar a = 0; a < AGC_CH; a++) begin : g_agc_rdy
            assign agc_iq_ready[a]   = take && mode.use_agc && (item.kind == ITEM_IQ)
                                       && (int'(item.sel) == a);
            assign agc_rssi_ready[a] = take && (item.kind == ITEM_RSSI) && (int'(item.sel) == a);
        end
    endgenerate

    // Quad-word walk: start on go, shift bytes out, finish after 16.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= '0;
            busy     <= 1'b0;
            byte_cnt <= '0;
            slot     <= '0;
            rem      <= '0;
            hold     <= '0;
            lp_valid <= 1'b0;
            lp_data  <= '0;
        end else if (!en) begin
            busy     <= 1'b0;
            rem      <= '0;
            lp_valid <= 1'b0;
        end else if (go) begin
            mode     <= ctrl;
            busy     <= 1'b1;
            byte_cnt <= '0;
            slot     <= '0;
            rem      <= '0;
            lp_valid <= 1'b0;
        end else begin
            lp_valid <= emit;
            if (emit) begin
                byte_cnt <= byte_cnt + BC_W'(1);
                if (byte_cnt == BC_W'(QUAD_BYTES - 1)) begin
                    busy <= 1'b0;
                end
                if (rem != 2'd0) begin
                    lp_data <= hold[IQ_BITS-9 -: 8];
                    hold    <= hold << 8;
                    rem     <= rem - 2'd1;
                end else if (take) begin
                    lp_data <= src_word[IQ_BITS-1 -: 8];
                    hold    <= src_word[IQ_BITS-9:0];
                    rem     <= (item.kind == ITEM_IQ) ? 2'd3 : 2'd1;
                    slot    <= slot + 3'd1;
                end else begin
                    lp_data <= 8'h00;
                end
            end
        end
    end

    p_stall_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (need_fetch && !src_valid && !go) |=> !lp_valid);

    p_quad_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_valid && $past(busy) && !busy) |=> !lp_valid);

endmodule

// File: rtl/linkport_seq.sv
// Top of the link port output sequencer. It joins the control register, the
// start-delay timer and the byte packer.
// Assumes all sources and the receiver share this clock.
module linkport_seq
    import lpseq_pkg::*;
#(
    parameter int FLT_CH   = 4,
    parameter int AGC_CH   = 2,
    parameter int RSSI_W   = 12,
    parameter int MIN_WAIT = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [7:0]               cfg_wdata,
    input  logic                     rx_rdy,
    input  logic [FLT_CH-1:0]        flt_valid,
    input  logic [FLT_CH*32-1:0]     flt_data,
    output logic [FLT_CH-1:0]        flt_ready,
    input  logic [AGC_CH-1:0]        agc_iq_valid,
    input  logic [AGC_CH*32-1:0]     agc_iq_data,
    output logic [AGC_CH-1:0]        agc_iq_ready,
    input  logic [AGC_CH-1:0]        agc_rssi_valid,
    input  logic [AGC_CH*RSSI_W-1:0] agc_rssi_data,
    output logic [AGC_CH-1:0]        agc_rssi_ready,
    output logic                     lp_valid,
    output logic [7:0]               lp_data
);

    ctrl_t ctrl;
    logic  go;
    logic  busy;

    lpseq_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .ctrl  (ctrl)
    );

    lpseq_start_timer #(
        .DLY_W    (4),
        .MIN_WAIT (MIN_WAIT)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ctrl.en),
        .rx_rdy (rx_rdy),
        .busy   (busy),
        .dly    (ctrl.dly),
        .go     (go)
    );

    lpseq_byte_packer #(
        .FLT_CH (FLT_CH),
        .AGC_CH (AGC_CH),
        .RSSI_W (RSSI_W)
    ) u_pack (
        .clk            (clk),
        .rst_n          (rst_n),
        .en             (ctrl.en),
        .go             (go),
        .ctrl           (ctrl),
        .flt_valid      (flt_valid),
        .flt_data       (flt_data),
        .flt_ready      (flt_ready),
        .agc_iq_valid   (agc_iq_valid),
        .agc_iq_data    (agc_iq_data),
        .agc_iq_ready   (agc_iq_ready),
        .agc_rssi_valid (agc_rssi_valid),
        .agc_rssi_data  (agc_rssi_data),
        .agc_rssi_ready (agc_rssi_ready),
        .busy           (busy),
        .lp_valid       (lp_valid),
        .lp_data        (lp_data)
    );

    p_quiet_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en |=> !lp_valid);

    p_one_take_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flt_ready, agc_iq_ready, agc_rssi_ready}));

    p_take_needs_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((flt_ready & ~flt_valid) == '0) && ((agc_iq_ready & ~agc_iq_valid) == '0)
        && ((agc_rssi_ready & ~agc_rssi_valid) == '0));

endmodule

// File: tb/sim_linkport_seq.sv
module sim_linkport_seq;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [7:0]   cfg_wdata = 8'h00;
    logic         rx_rdy = 1'b0;
    logic [3:0]   flt_valid = 4'hF;
    logic [127:0] flt_data;
    logic [3:0]   flt_ready;
    logic [1:0]   agc_iq_valid = 2'b11;
    logic [63:0]  agc_iq_data;
    logic [1:0]   agc_iq_ready;
    logic [1:0]   agc_rssi_valid = 2'b11;
    logic [23:0]  agc_rssi_data;
    logic [1:0]   agc_rssi_ready;
    logic         lp_valid;
    logic [7:0]   lp_data;

    int checks = 0;
    int bad = 0;

    always #4 clk = ~clk;

    localparam logic [31:0] FW0 = 32'hA0B0C0D0, FW1 = 32'hA1B1C1D1,
                            FW2 = 32'hA2B2C2D2, FW3 = 32'hA3B3C3D3;
    localparam logic [31:0] GA = 32'h10203040, GB = 32'h11213141;
    localparam logic [11:0] RA = 12'hABC, RB = 12'h5D7;

    assign flt_data      = {FW3, FW2, FW1, FW0};
    assign agc_iq_data   = {GB, GA};
    assign agc_rssi_data = {RB, RA};

    linkport_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .rx_rdy(rx_rdy), .flt_valid(flt_valid), .flt_data(flt_data),
        .flt_ready(flt_ready), .agc_iq_valid(agc_iq_valid),
        .agc_iq_data(agc_iq_data), .agc_iq_ready(agc_iq_ready),
        .agc_rssi_valid(agc_rssi_valid), .agc_rssi_data(agc_rssi_data),
        .agc_rssi_ready(agc_rssi_ready), .lp_valid(lp_valid), .lp_data(lp_data)
    );

    // Vector table: control byte, expected falling-edge count to first byte.
    localparam logic [15:0] VEC [8] = '{
        {8'h80, 8'd8}, {8'hCA, 8'd11}, {8'hAC, 8'd8}, {8'hFD, 8'd17},
        {8'hB9, 8'd9}, {8'hB3, 8'd8}, {8'h97, 8'd8}, {8'hE6, 8'd14}
    };

    // Expected quad-word from the control byte.
    function automatic logic [127:0] exp_quad(input logic [7:0] c);
        if (!c[0]) return c[1] ? {FW0, FW1, FW2, FW3} : {FW0, FW1, FW0, FW1};
        if (c[1])  return {GB, RB, 4'h0, 80'h0};
        if (c[2])  return {GA, GB, GA, GB};
        return {GA, RA, 4'h0, GB, RB, 4'h0, 32'h0};
    endfunction

    function automatic int exp_words(input logic [7:0] c);
        return (c[0] && c[1]) ? 2 : 4;
    endfunction

    function automatic string req_of(input logic [7:0] c);
        if (!c[0]) return c[2] ? "R5" : (c[1] ? "R4" : "R3");
        return c[1] ? "R8" : (c[2] ? "R6" : "R7");
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    int           q_k, q_readies, q_stalls, q_got;
    logic [127:0] q_bytes;
    logic         q_tail;
    int           release_after = 0;
    int           snap_at = -1;
    logic [7:0]   snap_val = 8'h00;

    function automatic int ready_count();
        return $countones({flt_ready, agc_iq_ready, agc_rssi_ready});
    endfunction

    // Raise data-ready, time the first byte, collect the quad-word.
    task automatic run_quad();
        q_k = 0; q_readies = 0; q_stalls = 0; q_got = 0; q_bytes = '0;
        @(negedge clk);
        rx_rdy = 1'b1;
        do begin
            @(negedge clk);
            rx_rdy = 1'b0;
            q_k++;
            q_readies += ready_count();
        end while (!lp_valid && q_k < 60);
        for (int g = 0; g < 200 && q_got < 16; g++) begin
            cfg_we = 1'b0;
            if (lp_valid) begin
                q_bytes[127 - 8*q_got -: 8] = lp_data;
                q_got++;
                if (snap_at == q_got) begin
                    cfg_we = 1'b1;
                    cfg_wdata = snap_val;
                end
            end else begin
                q_stalls++;
                if (release_after > 0 && q_stalls == release_after) flt_valid = 4'hF;
            end
            if (q_got < 16) begin
                @(negedge clk);
                q_readies += ready_count();
            end
        end
        @(negedge clk);
        cfg_we = 1'b0;
        q_readies += ready_count();
        q_tail = lp_valid;
    endtask

    initial begin : watchdog
        #1000000;
        bad++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(lp_valid == 1'b0, "R1", "lp_valid after reset", 128'(lp_valid), 0);
        check(ready_count() == 0, "R1", "readies after reset", 128'(ready_count()), 0);
        rst_n = 1'b1;
        @(negedge clk);
        rx_rdy = 1'b1;
        repeat (12) @(negedge clk);
        rx_rdy = 1'b0;
        check(lp_valid == 1'b0, "R1", "port off after reset", 128'(lp_valid), 0);

        // Table walk
        for (int i = 0; i < 8; i++) begin
            write_ctrl(VEC[i][15:8]);
            run_quad();
            check(q_k == int'(VEC[i][7:0]), "R9", "first-byte latency",
                  128'(q_k), 128'(VEC[i][7:0]));
            check(q_bytes == exp_quad(VEC[i][15:8]), req_of(VEC[i][15:8]), "quad bytes",
                  q_bytes, exp_quad(VEC[i][15:8]));
            check(q_stalls == 0 && !q_tail, "R11", "16 bytes back to back then idle",
                  128'({q_stalls, 31'(q_tail)}), 0);
            check(q_readies == exp_words(VEC[i][15:8]), "R12", "handshake count",
                  128'(q_readies), 128'(exp_words(VEC[i][15:8])));
        end

        // R10: channel 2 withheld, released after three stalled cycles
        write_ctrl(8'hB2);
        flt_valid = 4'b1011;
        release_after = 3;
        run_quad();
        release_after = 0;
        check(q_stalls == 3, "R10", "stall cycles", 128'(q_stalls), 3);
        check(q_bytes == exp_quad(8'hB2), "R10", "bytes after stall", q_bytes, exp_quad(8'hB2));

        // R11: write during transfer affects only the next quad-word
        write_ctrl(8'h80);
        snap_at = 2;
        snap_val = 8'h82;
        run_quad();
        snap_at = -1;
        check(q_bytes == exp_quad(8'h80), "R11", "mode held during quad", q_bytes, exp_quad(8'h80));
        run_quad();
        check(q_bytes == exp_quad(8'h82), "R11", "new mode on next quad", q_bytes, exp_quad(8'h82));

        // R2: disabled port ignores data-ready
        write_ctrl(8'h02);
        begin
            int seen = 0;
            @(negedge clk);
            rx_rdy = 1'b1;
            for (int t = 0; t < 30; t++) begin
                @(negedge clk);
                rx_rdy = 1'b0;
                seen += int'(lp_valid) + ready_count();
            end
            check(seen == 0, "R2", "activity while off", 128'(seen), 0);
            write_ctrl(8'h82);
            seen = 0;
            for (int t = 0; t < 20; t++) begin
                @(negedge clk);
                seen += int'(lp_valid);
            end
            check(seen == 0, "R2", "no late start after enable", 128'(seen), 0);
        end

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule